// File: doc/BRIEF.md
# USB Host Controller Fatal-Error and Interrupt Unit

This unit sits beside the bus-master DMA of a USB host controller. It watches the completion status of the memory reads the controller issues itself. When such a read comes back with a master abort or a target abort, the unit treats it as fatal. It records a host-system-error status, latches a halted state that stops new DMA work, and sets the matching abort and system-error flags in the function's configuration space.

The unit also holds two other interrupt causes. One marks the wrap of the frame index over a frame list with a parameterised number of entries, 1024 by default. The other marks a completion interrupt that the packet engine requests once the final status of an interval sits in its internal write buffer. All causes drive one level interrupt line through per-cause enable bits. Software clears the status bits by writing ones.

DMA work is gated through a request/grant pair that permits one outstanding USB transaction. A transaction that is already in flight when the fatal error arrives may still complete. No further one is started.

Top module: `usbhc_fault_intr`

## Requirements
- R1: After reset, the command, enable and configuration registers and the frame index read 0, the status register reads 0x0010 (only the halted bit 4 set), and `irq` and `txn_grant` are low.
- R2: A master or target abort strobe sets status bit 2 (host system error) and the halted bit 4 on the next clock edge. The halted state then persists even after the run bit (command bit 0) is written to 0, until a controller reset is written.
- R3: `txn_grant` is asserted only while run is set, no fatal error is latched and no transaction is outstanding. After a fatal error, at most one further `txn_done` is seen and no new grant is issued.
- R4: The host-system-error status raises `irq` only while enable bit 2 is set.
- R5: A master abort sets configuration bit 8 and a target abort sets configuration bit 9. Both arriving in one cycle set both bits and record a single fatal event.
- R6: Configuration bit 10 (signaled system error) is set by a fatal event only when configuration bit 0 (system-error enable) was set before that event.
- R7: While run is set and no fatal error is latched, each `frame_tick` advances the frame index (register 4). Going from FRAMES-1 to 0 sets status bit 1 (rollover). Ticks while stopped do not advance the index.
- R8: A `cpl_post` strobe sets status bit 0 (completion) on the next edge, without any further handshake.
- R9: `irq` is the OR of status bits 0 to 2, each ANDed with the same bit of the enable register (register 2). It stays high until the cause is cleared. Writing a one to a status bit clears it, writing a zero has no effect, and a set in the same cycle wins over a clear.
- R10: Writing command bit 1 resets the controller. Run, status bits, enables, the frame index and the fatal latch are cleared, while configuration bits 8 to 10 and bit 0 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register index: 0 command, 1 status, 2 enable, 3 configuration, 4 frame index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| rd_abort_ma | input | 1 | Master abort on a controller-issued memory read |
| rd_abort_ta | input | 1 | Target abort on a controller-issued memory read |
| txn_req | input | 1 | Packet engine requests to start a USB transaction |
| txn_grant | output | 1 | Permission to start that transaction |
| txn_done | input | 1 | The outstanding USB transaction has ended |
| cpl_post | input | 1 | Final status of an interrupt interval posted to the write buffer |
| frame_tick | input | 1 | One-millisecond frame boundary |
| halted | output | 1 | Controller halted (fatal latch, or stopped and idle) |
| irq | output | 1 | Level interrupt output |

## Verification
A wrong fatal latch shows at once on the ports. Either `halted` and status bit 2 fail to rise on the edge after an abort, or a new `txn_grant` appears in the very next cycle the packet engine requests. A wrong outstanding-transaction flag shows as a second grant one cycle after the first. A corrupted frame index only shows at the wrap, up to FRAMES ticks later, so the bench drives a full lap and reads the index just before and just after it. Errors in enable gating or in clear priority show on `irq` in the cycle after the offending write or strobe.

// File: rtl/usbhc_fi_pkg.sv
package usbhc_fi_pkg;
   // register indices
   localparam int ADR_CMD  = 0;
   localparam int ADR_STS  = 1;
   localparam int ADR_IEN  = 2;
   localparam int ADR_CFG  = 3;
   localparam int ADR_FIDX = 4;
   // command bits
   localparam int CMD_RUN   = 0;
   localparam int CMD_HCRST = 1;
   // status bits; the low NSRC bits are interrupt causes
   localparam int ST_DONE = 0;
   localparam int ST_ROLL = 1;
   localparam int ST_HSE  = 2;
   localparam int ST_HALT = 4;
   localparam int NSRC    = 3;
   // configuration bits
   localparam int CF_SERR = 0;
   localparam int CF_RMA  = 8;
   localparam int CF_RTA  = 9;
   localparam int CF_SSE  = 10;
   localparam int MIN_DW  = 16;
endpackage

// File: rtl/usbhc_fatal_capture.sv
module usbhc_fatal_capture
   import usbhc_fi_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          abort_ma,
   input  logic          abort_ta,
   input  logic          wr_cfg,
   input  logic [DW-1:0] wdata,
   output logic          fatal_evt,
   output logic          fatal_q,
   output logic [DW-1:0] cfg_q
);
   logic serr_en_q, rma_q, rta_q, sse_q;

   // a single event for one or both abort kinds
   assign fatal_evt = (abort_ma | abort_ta) & ~soft_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         serr_en_q <= 1'b0;
         rma_q     <= 1'b0;
         rta_q     <= 1'b0;
         sse_q     <= 1'b0;
         fatal_q   <= 1'b0;
      end else begin
         if (wr_cfg) serr_en_q <= wdata[CF_SERR];
         rma_q <= abort_ma | (rma_q & ~(wr_cfg & wdata[CF_RMA]));
         rta_q <= abort_ta | (rta_q & ~(wr_cfg & wdata[CF_RTA]));
         sse_q <= (fatal_evt & serr_en_q) | (sse_q & ~(wr_cfg & wdata[CF_SSE]));
         if (soft_rst)       fatal_q <= 1'b0;
         else if (fatal_evt) fatal_q <= 1'b1;
      end
   end

   always_comb begin
      cfg_q          = '0;
      cfg_q[CF_SERR] = serr_en_q;
      cfg_q[CF_RMA]  = rma_q;
      cfg_q[CF_RTA]  = rta_q;
      cfg_q[CF_SSE]  = sse_q;
   end
endmodule

// File: rtl/usbhc_dma_gate.sv
module usbhc_dma_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic run,
   input  logic fatal,
   input  logic txn_req,
   input  logic txn_done,
   output logic txn_grant,
   output logic busy_q
);
   assign txn_grant = txn_req & run & ~fatal & ~busy_q & ~soft_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy_q <= 1'b0;
      else if (soft_rst)  busy_q <= 1'b0;
      else if (txn_grant) busy_q <= 1'b1;
      else if (txn_done)  busy_q <= 1'b0;
   end
endmodule

// File: rtl/usbhc_frame_ctr.sv
module usbhc_frame_ctr #(
   parameter int FRAMES = 1024,
   localparam int FIDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              count_en,
   input  logic              tick,
   output logic [FIDX_W-1:0] idx_q,
   output logic              wrap
);
   localparam logic [FIDX_W-1:0] LAST = FIDX_W'(FRAMES - 1);
   localparam bit POW2 = (FRAMES == (1 << FIDX_W));

   logic step;
   logic [FIDX_W-1:0] idx_nx;

   assign step = tick & count_en & ~soft_rst;
   assign wrap = step & (idx_q == LAST);

   generate
      if (POW2) begin : g_pow2
         assign idx_nx = idx_q + 1'b1;
      end else begin : g_cmp
         assign idx_nx = (idx_q == LAST) ? '0 : idx_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        idx_q <= '0;
      else if (soft_rst) idx_q <= '0;
      else if (step)     idx_q <= idx_nx;
   end
endmodule

// File: rtl/usbhc_op_regs.sv
module usbhc_op_regs
   import usbhc_fi_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            soft_rst,
   input  logic            wr_cmd,
   input  logic            wr_sts,
   input  logic            wr_ien,
   input  logic [DW-1:0]   wdata,
   input  logic [NSRC-1:0] set_src,
   output logic            run_q,
   output logic [NSRC-1:0] sts_q,
   output logic [NSRC-1:0] ien_q,
   output logic            irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         ien_q <= '0;
      end else if (soft_rst) begin
         run_q <= 1'b0;
         ien_q <= '0;
      end else begin
         if (wr_cmd) run_q <= wdata[CMD_RUN];
         if (wr_ien) ien_q <= wdata[NSRC-1:0];
      end
   end

   // one write-one-to-clear cell per cause; a set beats a clear
   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_cause
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sts_q[i] <= 1'b0;
            else if (soft_rst) sts_q[i] <= 1'b0;
            else               sts_q[i] <= set_src[i] | (sts_q[i] & ~(wr_sts & wdata[i]));
         end
      end
   endgenerate

   assign irq = |(sts_q & ien_q);
endmodule

// File: rtl/usbhc_fault_intr.sv
module usbhc_fault_intr
   import usbhc_fi_pkg::*;
#(
   parameter int DW     = 16,
   parameter int AW     = 3,
   parameter int FRAMES = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          rd_abort_ma,
   input  logic          rd_abort_ta,
   input  logic          txn_req,
   output logic          txn_grant,
   input  logic          txn_done,
   input  logic          cpl_post,
   input  logic          frame_tick,
   output logic          halted,
   output logic          irq
);
   localparam int FIDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1;

   generate
      if (DW < MIN_DW) begin : g_bad_dw
         $error("usbhc_fault_intr: DW must be at least 16");
      end
      if (AW < 3) begin : g_bad_aw
         $error("usbhc_fault_intr: AW must be at least 3");
      end
      if (FRAMES < 2) begin : g_bad_frames
         $error("usbhc_fault_intr: FRAMES must be at least 2");
      end
      if (FIDX_W > DW) begin : g_bad_fidx
         $error("usbhc_fault_intr: frame index wider than DW");
      end
   endgenerate

   logic wr_cmd, wr_sts, wr_ien, wr_cfg, soft_rst;
   logic fatal_evt, fatal_q, busy_q, run_q, count_en, wrap;
   logic [DW-1:0]     cfg_q;
   logic [NSRC-1:0]   sts_q, ien_q, set_src;
   logic [FIDX_W-1:0] fidx;

   assign wr_cmd   = reg_wr && (reg_addr == AW'(ADR_CMD));
   assign wr_sts   = reg_wr && (reg_addr == AW'(ADR_STS));
   assign wr_ien   = reg_wr && (reg_addr == AW'(ADR_IEN));
   assign wr_cfg   = reg_wr && (reg_addr == AW'(ADR_CFG));
   assign soft_rst = wr_cmd && reg_wdata[CMD_HCRST];
   assign count_en = run_q & ~fatal_q;

   usbhc_fatal_capture #(.DW(DW)) u_fatal (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .abort_ma(rd_abort_ma), .abort_ta(rd_abort_ta),
      .wr_cfg(wr_cfg), .wdata(reg_wdata),
      .fatal_evt(fatal_evt), .fatal_q(fatal_q), .cfg_q(cfg_q)
   );

   usbhc_dma_gate u_gate (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .run(run_q), .fatal(fatal_q),
      .txn_req(txn_req), .txn_done(txn_done),
      .txn_grant(txn_grant), .busy_q(busy_q)
   );

   usbhc_frame_ctr #(.FRAMES(FRAMES)) u_frame (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .count_en(count_en), .tick(frame_tick),
      .idx_q(fidx), .wrap(wrap)
   );

   always_comb begin
      set_src          = '0;
      set_src[ST_DONE] = cpl_post;
      set_src[ST_ROLL] = wrap;
      set_src[ST_HSE]  = fatal_evt;
   end

   usbhc_op_regs #(.DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_cmd(wr_cmd), .wr_sts(wr_sts), .wr_ien(wr_ien),
      .wdata(reg_wdata), .set_src(set_src),
      .run_q(run_q), .sts_q(sts_q), .ien_q(ien_q), .irq(irq)
   );

   assign halted = fatal_q | (~run_q & ~busy_q);

   always_comb begin
      reg_rdata = '0;
      case (int'(reg_addr))
         ADR_CMD: reg_rdata[CMD_RUN] = run_q;
         ADR_STS: begin
            reg_rdata[NSRC-1:0] = sts_q;
            reg_rdata[ST_HALT]  = halted;
         end
         ADR_IEN:  reg_rdata[NSRC-1:0]   = ien_q;
         ADR_CFG:  reg_rdata             = cfg_q;
         ADR_FIDX: reg_rdata[FIDX_W-1:0] = fidx;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/usbhc_fault_intr_chk.sv
module usbhc_fault_intr_chk #(
   parameter int FIDX_W = 10,
   parameter int FRAMES = 1024
) (
   input logic              clk,
   input logic              rst_n,
   input logic              abort_ma,
   input logic              abort_ta,
   input logic              soft_rst,
   input logic              fatal_evt,
   input logic              fatal_q,
   input logic              txn_grant,
   input logic              txn_done,
   input logic              irq,
   input logic              reg_wr,
   input logic              cfg_serr,
   input logic              cfg_sse,
   input logic              frame_tick,
   input logic              count_en,
   input logic [FIDX_W-1:0] fidx,
   input logic              roll_sts
);
   logic [1:0] done_after_fatal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              done_after_fatal <= '0;
      else if (!fatal_q)                       done_after_fatal <= '0;
      else if (txn_done && done_after_fatal != 2'd3) done_after_fatal <= done_after_fatal + 2'd1;
   end

   AST_ABORT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_ma || abort_ta) && !soft_rst |=> fatal_q); // R2
   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_q && !soft_rst |=> fatal_q); // R2
   AST_NO_GRANT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_q |-> !txn_grant); // R3
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      txn_grant |=> !txn_grant); // R3
   AST_ONE_MORE_TXN: assert property (@(posedge clk) disable iff (!rst_n)
      done_after_fatal <= 2'd1); // R3
   AST_SSE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_sse) |-> $past(cfg_serr) && $past(fatal_evt)); // R6
   AST_ROLL_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick && count_en && !soft_rst && (fidx == FIDX_W'(FRAMES - 1)) |=> roll_sts); // R7
   AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !reg_wr |=> irq); // R9
endmodule

bind usbhc_fault_intr usbhc_fault_intr_chk #(.FIDX_W(FIDX_W), .FRAMES(FRAMES)) chk_i (
   .clk(clk), .rst_n(rst_n),
   .abort_ma(rd_abort_ma), .abort_ta(rd_abort_ta),
   .soft_rst(soft_rst), .fatal_evt(fatal_evt), .fatal_q(fatal_q),
   .txn_grant(txn_grant), .txn_done(txn_done),
   .irq(irq), .reg_wr(reg_wr),
   .cfg_serr(cfg_q[usbhc_fi_pkg::CF_SERR]), .cfg_sse(cfg_q[usbhc_fi_pkg::CF_SSE]),
   .frame_tick(frame_tick), .count_en(count_en), .fidx(fidx),
   .roll_sts(sts_q[usbhc_fi_pkg::ST_ROLL])
);

// File: tb/usbhc_fault_intr_tb.sv
module usbhc_fault_intr_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int AW = 3;
   localparam int FRAMES = 1024;

   // vector operations
   localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_MA = 3'd2, OP_TA = 3'd3,
                          OP_BOTH = 3'd4, OP_POST = 3'd5;

   typedef struct packed {
      logic [2:0]  op;
      logic [2:0]  addr;
      logic [15:0] data;
      logic        irq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 37;
   localparam vec_t VECS [0:NV-1] = '{
      '{OP_WR,   3'd2, 16'h0007, 1'b0, 4'd9},
      '{OP_WR,   3'd0, 16'h0001, 1'b0, 4'd2},
      '{OP_RD,   3'd1, 16'h0000, 1'b0, 4'd2},   // R2 running, not halted
      '{OP_POST, 3'd0, 16'h0000, 1'b0, 4'd8},
      '{OP_RD,   3'd1, 16'h0001, 1'b1, 4'd8},   // R8
      '{OP_WR,   3'd1, 16'h0000, 1'b0, 4'd9},
      '{OP_RD,   3'd1, 16'h0001, 1'b1, 4'd9},   // R9 zero write no effect
      '{OP_WR,   3'd1, 16'h0001, 1'b0, 4'd9},
      '{OP_RD,   3'd1, 16'h0000, 1'b0, 4'd9},   // R9 cleared
      '{OP_WR,   3'd2, 16'h0000, 1'b0, 4'd9},
      '{OP_POST, 3'd0, 16'h0000, 1'b0, 4'd9},
      '{OP_RD,   3'd1, 16'h0001, 1'b0, 4'd9},   // R9 masked
      '{OP_WR,   3'd1, 16'h0001, 1'b0, 4'd9},
      '{OP_WR,   3'd3, 16'h0001, 1'b0, 4'd6},
      '{OP_MA,   3'd0, 16'h0000, 1'b0, 4'd2},
      '{OP_RD,   3'd1, 16'h0014, 1'b0, 4'd4},   // R2 R4 no enable
      '{OP_RD,   3'd3, 16'h0501, 1'b0, 4'd5},   // R5 R6
      '{OP_WR,   3'd2, 16'h0004, 1'b0, 4'd4},
      '{OP_RD,   3'd1, 16'h0014, 1'b1, 4'd4},   // R4 enabled
      '{OP_WR,   3'd0, 16'h0000, 1'b0, 4'd2},
      '{OP_RD,   3'd1, 16'h0014, 1'b1, 4'd2},   // R2 halt persists
      '{OP_WR,   3'd0, 16'h0002, 1'b0, 4'd10},
      '{OP_RD,   3'd1, 16'h0010, 1'b0, 4'd10},  // R10
      '{OP_RD,   3'd2, 16'h0000, 1'b0, 4'd10},  // R10 enables cleared
      '{OP_RD,   3'd3, 16'h0501, 1'b0, 4'd10},  // R10 config kept
      '{OP_WR,   3'd3, 16'h0700, 1'b0, 4'd5},
      '{OP_RD,   3'd3, 16'h0000, 1'b0, 4'd5},
      '{OP_WR,   3'd0, 16'h0001, 1'b0, 4'd5},
      '{OP_TA,   3'd0, 16'h0000, 1'b0, 4'd5},
      '{OP_RD,   3'd3, 16'h0200, 1'b0, 4'd6},   // R5 R6 no SSE
      '{OP_WR,   3'd0, 16'h0002, 1'b0, 4'd10},
      '{OP_WR,   3'd3, 16'h0200, 1'b0, 4'd5},
      '{OP_WR,   3'd2, 16'h0004, 1'b0, 4'd5},
      '{OP_WR,   3'd0, 16'h0001, 1'b0, 4'd5},
      '{OP_BOTH, 3'd0, 16'h0000, 1'b0, 4'd5},
      '{OP_RD,   3'd3, 16'h0300, 1'b1, 4'd5},   // R5 both flags
      '{OP_RD,   3'd1, 16'h0014, 1'b1, 4'd5}    // R5 single event
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          rd_abort_ma = 1'b0, rd_abort_ta = 1'b0;
   logic          txn_req = 1'b0, txn_done = 1'b0;
   logic          txn_grant, halted, irq;
   logic          cpl_post = 1'b0, frame_tick = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usbhc_fault_intr #(.DW(DW), .AW(AW), .FRAMES(FRAMES)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rd_abort_ma(rd_abort_ma), .rd_abort_ta(rd_abort_ta),
      .txn_req(txn_req), .txn_grant(txn_grant), .txn_done(txn_done),
      .cpl_post(cpl_post), .frame_tick(frame_tick),
      .halted(halted), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // one clock with the current inputs, then strobes drop at the negedge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0; rd_abort_ma = 1'b0; rd_abort_ta = 1'b0;
      cpl_post = 1'b0; frame_tick = 1'b0; txn_done = 1'b0;
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      step();
   endtask

   task automatic rd_chk(input string req, input int a, input logic [15:0] exp);
      reg_addr = AW'(a);
      #1;
      check(req, 32'(reg_rdata), 32'(exp));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      rd_chk("R1 cmd", 0, 16'h0000);
      rd_chk("R1 sts", 1, 16'h0010);
      rd_chk("R1 ien", 2, 16'h0000);
      rd_chk("R1 cfg", 3, 16'h0000);
      rd_chk("R1 fidx", 4, 16'h0000);
      check("R1 irq", 32'(irq), 32'd0);
      txn_req = 1'b1; #1;
      check("R1 grant", 32'(txn_grant), 32'd0);
      txn_req = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      // vector walk
      for (int i = 0; i < NV; i++) begin
         case (VECS[i].op)
            OP_WR:   wr(int'(VECS[i].addr), VECS[i].data);
            OP_MA:   begin rd_abort_ma = 1'b1; step(); end
            OP_TA:   begin rd_abort_ta = 1'b1; step(); end
            OP_BOTH: begin rd_abort_ma = 1'b1; rd_abort_ta = 1'b1; step(); end
            OP_POST: begin cpl_post = 1'b1; step(); end
            default: begin
               rd_chk($sformatf("R%0d vec%0d rdata", VECS[i].req, i), int'(VECS[i].addr), VECS[i].data);
               check($sformatf("R%0d vec%0d irq", VECS[i].req, i), 32'(irq), 32'(VECS[i].irq));
            end
         endcase
      end

      // R3 one outstanding transaction and halt allowance
      wr(0, 16'h0002);
      wr(0, 16'h0001);
      txn_req = 1'b1; #1;
      check("R3 grant when idle", 32'(txn_grant), 32'd1);
      step();
      check("R3 no grant while busy", 32'(txn_grant), 32'd0);
      rd_abort_ma = 1'b1;
      step();
      check("R3 halted after abort", 32'(halted), 32'd1);
      txn_done = 1'b1;
      step();
      check("R3 no grant after in-flight done", 32'(txn_grant), 32'd0);
      step();
      check("R3 still no grant", 32'(txn_grant), 32'd0);
      txn_req = 1'b0;
      wr(0, 16'h0002);
      check("R10 halted cleared to stopped", 32'(halted), 32'd1);
      wr(0, 16'h0001);
      check("R2 running not halted", 32'(halted), 32'd0);
      txn_req = 1'b1; #1;
      check("R3 grant after controller reset", 32'(txn_grant), 32'd1);
      step();
      txn_req = 1'b0; txn_done = 1'b1;
      step();

      // R9 set wins over same-cycle clear
      wr(2, 16'h0001);
      cpl_post = 1'b1; reg_wr = 1'b1; reg_addr = AW'(1); reg_wdata = 16'h0001;
      step();
      rd_chk("R9 set beats clear", 1, 16'h0001);
      check("R9 irq level", 32'(irq), 32'd1);
      wr(1, 16'h0001);
      check("R9 irq drops after clear", 32'(irq), 32'd0);

      // R7 frame index and rollover
      wr(0, 16'h0002);
      frame_tick = 1'b1; step();
      rd_chk("R7 stopped ignores tick", 4, 16'h0000);
      wr(2, 16'h0002);
      wr(0, 16'h0001);
      for (int k = 0; k < FRAMES - 1; k++) begin
         frame_tick = 1'b1; step();
      end
      rd_chk("R7 index before wrap", 4, 16'(FRAMES - 1));
      rd_chk("R7 no rollover yet", 1, 16'h0000);
      frame_tick = 1'b1; step();
      rd_chk("R7 index wraps", 4, 16'h0000);
      rd_chk("R7 rollover set", 1, 16'h0002);
      check("R7 rollover irq", 32'(irq), 32'd1);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule